// File: doc/BRIEF.md
# Power-of-Two Clock Divider with Instantaneous Phase Jumps

This block turns a slow enable pulse train, one pulse per prescaled input event, into a low-frequency divided clock. The division ratio is a power of two, 2^n, and the exponent n is chosen at run time. Internally a count register advances by one on every enable pulse and wraps at the selected ratio. The divided clock is the top bit of the active count range. It is low for the first half of each period and high for the second half.

A phase jump moves the output phase at once instead of slewing it. On a jump strobe, a signed two's-complement amount is added to the count modulo the ratio, so a jump can go forward or backward by any whole number of enable periods. An amount larger than the ratio wraps. Changing the exponent restarts the count from zero. An exponent outside the supported range is clamped to the nearest end of that range.

Top module: `divr_phase_jump`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises with no tick, jump or exponent change, div_out is 0. The count is 0 and the held exponent is N_MIN.
- R2: With no jump and no exponent change, each clock edge with tick high adds one to the count. div_out equals bit n-1 of the count, where n is the held exponent.
- R3: The count wraps to 0 after 2^n - 1, so div_out has a period of 2^n ticks: low for 2^(n-1) ticks, then high for 2^(n-1) ticks.
- R4: On an edge with tick low, jump_stb low and no exponent change, the count is unchanged.
- R5: On an edge with jump_stb high and no exponent change, the count becomes (count + J) mod 2^n. J is jump_amt read as a signed two's-complement value.
- R6: A jump takes precedence over a tick on the same edge, and that tick is not counted.
- R7: A jump whose magnitude is 2^n or more is reduced modulo 2^n. For example, +2^n + k has the same effect as +k.
- R8: When the clamped exp_sel differs from the held exponent, the next edge loads the new exponent and sets the count to 0. This overrides any jump or tick on that edge.
- R9: An exp_sel below N_MIN (5) acts as N_MIN, and one above N_MAX (30) acts as N_MAX. A change between two values that clamp to the same exponent causes no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled enable; the count advances once per high cycle |
| jump_stb | input | 1 | Jump strobe; applies jump_amt on this edge |
| jump_amt | input | JMP_W (32) | Signed two's-complement jump amount, in ticks |
| exp_sel | input | EXP_W (5) | Division exponent n; ratio is 2^n |
| div_out | output | 1 | Divided clock, bit n-1 of the count |

## Verification
The bench builds the block with its default parameters: a 30-bit count, a 32-bit jump amount, and an exponent range of 5 to 30. It sweeps whole output periods for exponents 5 to 8, with idle cycles mixed in. With the exponent at 5, it sweeps every jump amount from -70 to +70, which covers backward jumps, forward jumps and amounts beyond two full ratios. Exponent values 2, 31 and 30 exercise clamping at both ends. At the top end, jumps of 2^29 and -1 reach the widest count, whose full period is too long to sweep.

// File: rtl/divr_pkg.sv
package divr_pkg;

   // Per-edge action chosen for the count register, highest priority last.
   typedef enum logic [1:0] {
      ACT_HOLD    = 2'd0,
      ACT_TICK    = 2'd1,
      ACT_JUMP    = 2'd2,
      ACT_RESTART = 2'd3
   } divr_act_e;

endpackage

// File: rtl/divr_exp_sel.sv
// Clamps the requested exponent into range, holds it, and flags a change.
module divr_exp_sel #(
   parameter int EXP_W = 5,
   parameter int N_MIN = 5,
   parameter int N_MAX = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] exp_req,
   output logic [EXP_W-1:0] exp_q,
   output logic             restart
);
   localparam logic [EXP_W-1:0] LO = EXP_W'(N_MIN);
   localparam logic [EXP_W-1:0] HI = EXP_W'(N_MAX);

   logic [EXP_W-1:0] exp_clamped;

   always_comb begin
      if (exp_req < LO)      exp_clamped = LO;
      else if (exp_req > HI) exp_clamped = HI;
      else                   exp_clamped = exp_req;
   end

   assign restart = (exp_clamped != exp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       exp_q <= LO;
      else if (restart) exp_q <= exp_clamped;
   end
endmodule

// File: rtl/divr_mask_gen.sv
// Builds the modulus mask (bits below n) and the one-hot output tap (bit n-1).
module divr_mask_gen #(
   parameter int CNT_W = 30,
   parameter int EXP_W = 5
) (
   input  logic [EXP_W-1:0] exp_q,
   output logic [CNT_W-1:0] mask,
   output logic [CNT_W-1:0] tap
);
   for (genvar i = 0; i < CNT_W; i++) begin : g_bit
      assign mask[i] = (int'(exp_q) > i);
      assign tap[i]  = (int'(exp_q) == i + 1);
   end
endmodule

// File: rtl/divr_counter.sv
// Count register: hold, increment, signed modular jump, or restart.
module divr_counter
   import divr_pkg::*;
#(
   parameter int CNT_W = 30,
   parameter int JMP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  divr_act_e        act,
   input  logic [JMP_W-1:0] jump_amt,
   input  logic [CNT_W-1:0] mask,
   output logic [CNT_W-1:0] count_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] jump_ext;
   logic [CNT_W-1:0] count_d;

   // Arithmetic is done modulo 2^CNT_W; since 2^n divides that, masking
   // afterwards gives the residue mod 2^n for either sign of the amount.
   if (JMP_W > CNT_W) begin : g_drop
      logic unused_jump_hi;
      assign unused_jump_hi = ^jump_amt[JMP_W-1:CNT_W];
      assign jump_ext       = jump_amt[CNT_W-1:0];
   end else if (JMP_W == CNT_W) begin : g_exact
      assign jump_ext = jump_amt;
   end else begin : g_sext
      assign jump_ext = {{(CNT_W-JMP_W){jump_amt[JMP_W-1]}}, jump_amt};
   end

   always_comb begin
      unique case (act)
         ACT_RESTART: count_d = '0;
         ACT_JUMP:    count_d = (count_q + jump_ext) & mask;
         ACT_TICK:    count_d = (count_q + ONE) & mask;
         default:     count_d = count_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end
endmodule

// File: rtl/divr_phase_jump.sv
module divr_phase_jump
   import divr_pkg::*;
#(
   parameter int CNT_W = 30,
   parameter int JMP_W = 32,
   parameter int N_MIN = 5,
   parameter int N_MAX = 30,
   parameter int EXP_W = $clog2(N_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             jump_stb,
   input  logic [JMP_W-1:0] jump_amt,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             div_out
);
   // Elaboration-time parameter checks.
   if (N_MIN < 1) begin : g_bad_min
      $error("divr_phase_jump: N_MIN must be at least 1");
   end
   if (N_MAX < N_MIN) begin : g_bad_range
      $error("divr_phase_jump: N_MAX must not be below N_MIN");
   end
   if (N_MAX > CNT_W) begin : g_bad_width
      $error("divr_phase_jump: N_MAX must not exceed CNT_W");
   end
   if ((1 << EXP_W) <= N_MAX) begin : g_bad_exp_w
      $error("divr_phase_jump: EXP_W too narrow for N_MAX");
   end

   logic [EXP_W-1:0] exp_q;
   logic             restart;
   logic [CNT_W-1:0] mask;
   logic [CNT_W-1:0] tap;
   logic [CNT_W-1:0] count_q;
   divr_act_e        act;

   divr_exp_sel #(.EXP_W(EXP_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_exp (
      .clk     (clk),
      .rst_n   (rst_n),
      .exp_req (exp_sel),
      .exp_q   (exp_q),
      .restart (restart)
   );

   divr_mask_gen #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_mask (
      .exp_q (exp_q),
      .mask  (mask),
      .tap   (tap)
   );

   // Priority: exponent change, then jump, then tick.
   always_comb begin
      if (restart)       act = ACT_RESTART;
      else if (jump_stb) act = ACT_JUMP;
      else if (tick)     act = ACT_TICK;
      else               act = ACT_HOLD;
   end

   divr_counter #(.CNT_W(CNT_W), .JMP_W(JMP_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .jump_amt (jump_amt),
      .mask     (mask),
      .count_q  (count_q)
   );

   assign div_out = |(count_q & tap);
endmodule

// File: rtl/divr_phase_jump_chk.sv
module divr_phase_jump_chk #(
   parameter int CNT_W = 30,
   parameter int JMP_W = 32,
   parameter int N_MIN = 5,
   parameter int N_MAX = 30,
   parameter int EXP_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             jump_stb,
   input logic [JMP_W-1:0] jump_amt,
   input logic [EXP_W-1:0] exp_sel,
   input logic [EXP_W-1:0] exp_q,
   input logic [CNT_W-1:0] count_q,
   input logic             div_out
);
   logic [EXP_W-1:0] want_exp;
   logic             chg;
   logic [CNT_W:0]   full;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] jx;

   assign want_exp = (int'(exp_sel) < N_MIN) ? EXP_W'(N_MIN) :
                     (int'(exp_sel) > N_MAX) ? EXP_W'(N_MAX) : exp_sel;
   assign chg  = (want_exp != exp_q);
   assign full = ((CNT_W+1)'(1) << exp_q) - (CNT_W+1)'(1);
   assign lim  = full[CNT_W-1:0];
   assign jx   = CNT_W'($signed(jump_amt));

   p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q & ~lim) == '0);

   p_exp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(exp_q) >= N_MIN) && (int'(exp_q) <= N_MAX));

   p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (count_q == '0) && (exp_q == $past(want_exp)) && !div_out);

   p_jump_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_stb && !chg) |=>
         count_q == (($past(count_q) + $past(jx)) & $past(lim)));

   p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !jump_stb && !chg) |=>
         count_q == (($past(count_q) + CNT_W'(1)) & $past(lim)));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !jump_stb && !chg) |=> $stable(count_q));
endmodule

bind divr_phase_jump divr_phase_jump_chk #(
   .CNT_W(CNT_W), .JMP_W(JMP_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .EXP_W(EXP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .jump_stb (jump_stb),
   .jump_amt (jump_amt),
   .exp_sel  (exp_sel),
   .exp_q    (exp_q),
   .count_q  (count_q),
   .div_out  (div_out)
);

// File: tb/sim_divr_phase_jump.sv
module sim_divr_phase_jump;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 30;
   localparam int JMP_W = 32;
   localparam int N_MIN = 5;
   localparam int N_MAX = 30;
   localparam int EXP_W = 5;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             tick;
   logic             jump_stb;
   logic [JMP_W-1:0] jump_amt;
   logic [EXP_W-1:0] exp_sel;
   logic             div_out;

   int     errors = 0;
   int     checks = 0;
   longint mcount = 0;
   int     mexp   = N_MIN;
   bit     done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   divr_phase_jump #(.CNT_W(CNT_W), .JMP_W(JMP_W), .N_MIN(N_MIN), .N_MAX(N_MAX),
                     .EXP_W(EXP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .jump_stb(jump_stb),
      .jump_amt(jump_amt), .exp_sel(exp_sel), .div_out(div_out)
   );

   function automatic int clampx(int e);
      if (e < N_MIN) return N_MIN;
      if (e > N_MAX) return N_MAX;
      return e;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: div_out=%0b expected=%0b (count model %0d, n=%0d)",
                  tag, act, exp, mcount, mexp);
      end
   endtask

   // One clock edge of stimulus, model update from the requirements, check.
   task automatic step(bit t, bit s, longint j, int e, string tag);
      longint msk;
      int     ce;
      @(negedge clk);
      tick = t; jump_stb = s; jump_amt = j[JMP_W-1:0]; exp_sel = EXP_W'(e);
      @(posedge clk);
      ce = clampx(e);
      if (ce != mexp) begin
         mexp = ce; mcount = 0;
      end else begin
         msk = (longint'(1) << mexp) - 1;
         if (s)      mcount = (mcount + j) & msk;
         else if (t) mcount = (mcount + 1) & msk;
      end
      #1;
      chk(tag, div_out, logic'((mcount >> (mexp - 1)) & 1));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; jump_stb = 1'b0; jump_amt = '0; exp_sel = EXP_W'(N_MIN);
      repeat (3) @(posedge clk);
      #1 chk("R1 in reset", div_out, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < 3; k++) step(0, 0, 0, N_MIN, "R1");

      // Full periods for several exponents with idle cycles mixed in.
      for (int n = 5; n <= 8; n++) begin
         step(0, 0, 0, n, "R8");
         for (int k = 0; k < (2 << n) + 5; k++) begin
            if (k % 5 == 4) step(0, 0, 0, n, "R4");
            step(1, 0, 0, n, "R2/R3");
         end
      end

      // Jump sweep at n=5; odd amounts arrive with tick high as well.
      step(0, 0, 0, 5, "R8");
      for (int j = -70; j <= 70; j++) begin
         if (j % 2 != 0) step(1, 1, j, 5, "R6");
         else            step(0, 1, j, 5, (j > 31 || j < -31) ? "R7" : "R5");
         for (int k = 0; k < 33; k++) step(1, 0, 0, 5, "R5 after jump");
      end

      // Exponent change overrides a simultaneous jump and tick.
      for (int k = 0; k < 20; k++) step(1, 0, 0, 5, "R2");
      step(1, 1, 7, 6, "R8 override");
      for (int k = 0; k < 70; k++) step(1, 0, 0, 6, "R8 then count");

      // Clamping at both ends.
      step(1, 0, 0, 2, "R9 low clamp");
      for (int k = 0; k < 40; k++) step(1, 0, 0, 2, "R9 low");
      step(0, 0, 0, 31, "R9 high clamp");
      step(0, 1, longint'(1) << 29, 31, "R9 half");
      step(0, 1, longint'(1) << 29, 31, "R9 wrap");
      step(0, 1, -1, 31, "R9 back");
      step(0, 0, 0, 30, "R9 same clamp");
      step(1, 0, 0, 30, "R9 top wrap");
      step(0, 1, -1, 30, "R5 wide");
      step(1, 1, 1, 30, "R6 wide");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule